// File: doc/BRIEF.md
# Switchable Bypass FIFO with Fill Status

This block sits on the output path of a sampling converter and holds up to 16 conversion results of 18 bits each: 16 data bits, an inverted copy of the most significant bit and an overflow flag. A mode input chooses between two paths. In buffered mode, every completed conversion is written into the FIFO with no further command. The oldest stored word falls through to the output and stays there. Edges on a read line step the output through the stored words. In pass-through mode the input word goes straight to the output. The FIFO then ignores writes and reads and keeps its contents.

The FIFO reports its fill level on two status outputs. A reset that software can reach needs no extra pin: with the mode input in pass-through and the read line held low, the FIFO empties. The read line is asynchronous, so the block passes it through two synchronizer stages and detects its edges on the system clock. A write is marked by the falling edge of the end-of-conversion input, which is assumed to be synchronous to the clock.

Top module: `bypass_fifo`

## Requirements
- R1: With `fifo_mode` = 0, `dout` equals `din` combinationally.
- R2: With `fifo_mode` = 0 and the read line high, end-of-conversion falling edges and read-line edges change neither the stored words nor the status.
- R3: With `fifo_mode` = 1, a 1-to-0 transition of `eoc` writes `din` in the clock edge where `eoc` is first seen low, whatever the level of the read line, and the status reflects the write at that edge.
- R4: After a write into an empty FIFO, that word appears on `dout` from the following cycle and stays there until a read advances it.
- R5: When two or more words are held, a rising read edge removes the word on `dout` and presents the next oldest one.
- R6: When one word is held, a rising read edge leaves it on `dout`. The next falling read edge then empties the FIFO, and the word stays on `dout`.
- R7: Read edges while the FIFO is empty leave `dout` unchanged.
- R8: A write while 16 words are held is discarded. The held words and `dout` are unchanged.
- R9: Status as (`st_upper`, `st_lower`): empty = (0,1), 1 to 7 words = (0,0), 8 to 15 words = (1,0), 16 words = (1,1).
- R10: `fifo_mode` = 0 together with a synchronized low read line empties the FIFO at the next clock edge.
- R11: The read line passes two synchronizer flops. A level change takes effect at the third rising clock edge after it. A write and a read edge in the same cycle act as write first, then read.
- R12: After `rst_n` is asserted, the FIFO is empty and `dout` in buffered mode is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 = buffered through FIFO, 0 = pass-through |
| rd_line | input | 1 | Asynchronous read line; its edges step the FIFO |
| eoc | input | 1 | End of conversion; falling edge writes `din` |
| din | input | 18 | Conversion word {overflow, inverted MSB, data} |
| dout | output | 18 | Output word |
| st_upper | output | 1 | Fill status, upper bit |
| st_lower | output | 1 | Fill status, lower bit |

## Verification
The bench fills the FIFO to 16 words and pushes a 17th. A design that accepts this word would corrupt the oldest entry or wrap its count to empty. It then makes a write and a read edge land in the same clock edge while the FIFO is full. Read-first ordering would end full instead of at 15 words. It drains the FIFO down to the last word to check that emptying waits for the falling edge and that the word stays on `dout` afterwards. A design that pops on the rising edge would show empty one half-cycle early. A design that clears the output would lose the word. The bench also checks that pass-through mode with the read line high freezes the contents, and that pulling the line low empties the FIFO. Mixing these two cases up would either lose stored data or fail to reset.

// File: rtl/bypass_fifo.sv
module bypass_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int W  = DATA_W + 2,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fifo_mode,
  input  logic         rd_line,
  input  logic         eoc,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         st_upper,
  output logic         st_lower
);
  localparam int HALF = DEPTH / 2;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] head, tail;
  logic [CW-1:0] count, cnt_w;
  logic [W-1:0]  last_q;
  logic          pend;
  logic          rs1, rs2, rs3, eoc_q;

  wire rd_rise  = rs2 & ~rs3;
  wire rd_fall  = ~rs2 & rs3;
  wire wr_fire  = fifo_mode & eoc_q & ~eoc;
  wire wr_ok    = wr_fire & (count != CW'(DEPTH));
  wire soft_clr = ~fifo_mode & ~rs2;

  assign cnt_w = count + CW'(wr_ok);

  wire pop_now  = fifo_mode & rd_rise & (cnt_w >= CW'(2));
  wire pend_set = fifo_mode & rd_rise & (cnt_w == CW'(1));
  wire pop_late = fifo_mode & rd_fall & pend;
  wire pop      = pop_now | pop_late;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1   <= 1'b0;
      rs2   <= 1'b0;
      rs3   <= 1'b0;
      eoc_q <= 1'b0;
    end else begin
      rs1   <= rd_line;
      rs2   <= rs1;
      rs3   <= rs2;
      eoc_q <= eoc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[tail] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head   <= '0;
      tail   <= '0;
      count  <= '0;
      pend   <= 1'b0;
      last_q <= '0;
    end else if (soft_clr) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      pend  <= 1'b0;
    end else begin
      if (wr_ok) tail <= tail + AW'(1);
      if (pop) head <= head + AW'(1);
      if (pop_late) begin
        last_q <= mem[head];
        pend   <= 1'b0;
      end else if (pend_set) begin
        pend <= 1'b1;
      end
      count <= cnt_w - CW'(pop);
    end
  end

  assign dout     = !fifo_mode      ? din
                  : (count != '0)   ? mem[head]
                  :                   last_q;
  assign st_upper = count >= CW'(HALF);
  assign st_lower = (count == '0) | (count == CW'(DEPTH));
endmodule

module bypass_fifo_chk #(
  parameter int W = 18,
  parameter int DEPTH = 16,
  parameter int CW = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fifo_mode,
  input logic         rs2,
  input logic         rd_rise,
  input logic         rd_fall,
  input logic         wr_fire,
  input logic [CW-1:0] count,
  input logic [W-1:0] dout,
  input logic         st_upper,
  input logic         st_lower
);
  // R2
  direct_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && rs2) |=> $stable(count));

  // R10
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && !rs2) |=> (!st_upper && st_lower));

  // R8
  full_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && count == CW'(DEPTH) && !rd_rise && !rd_fall) |=> (count == CW'(DEPTH)));

  // R7
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && count == '0 && !wr_fire) |=> (!fifo_mode || $stable(dout)));

  // R11
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode |=> (count == $past(count) || count == $past(count) + 1'b1
                   || count == $past(count) - 1'b1));

  // R9
  status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_upper && st_lower) |-> (count == CW'(DEPTH)));
endmodule

bind bypass_fifo bypass_fifo_chk #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rs2(rs2),
  .rd_rise(rd_rise), .rd_fall(rd_fall), .wr_fire(wr_fire), .count(count),
  .dout(dout), .st_upper(st_upper), .st_lower(st_lower)
);

// File: tb/tb_bypass_fifo.sv
module tb_bypass_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 1'b1;
  logic rd_line = 1'b1;
  logic eoc = 1'b1;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic st_upper, st_lower;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [17:0] mq[$];
  bit pend_m = 0;
  logic [17:0] last_m = '0;

  bypass_fifo dut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rd_line(rd_line),
    .eoc(eoc), .din(din), .dout(dout), .st_upper(st_upper), .st_lower(st_lower)
  );

  always #10 clk = ~clk;

  function automatic logic [1:0] exp_status(int n);
    if (n == 0) return 2'b01;
    if (n == 16) return 2'b11;
    if (n >= 8) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [17:0] exp_dout();
    if (!fifo_mode) return din;
    if (mq.size() > 0) return mq[0];
    return last_m;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [17:0] ed;
    logic [1:0] es;
    ed = exp_dout();
    es = exp_status(mq.size());
    chk(dout === ed, {tag, " dout"}, 32'(dout), 32'(ed));
    chk({st_upper, st_lower} === es, {tag, " status R9"}, 32'({st_upper, st_lower}), 32'(es));
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic model_clear();
    mq.delete();
    pend_m = 0;
  endtask

  task automatic do_write(logic [17:0] w);
    din = w;
    eoc = 1'b0;
    if (fifo_mode && mq.size() < 16) mq.push_back(w);
    settle();
    eoc = 1'b1;
    @(negedge clk);
  endtask

  task automatic model_rise();
    if (mq.size() >= 2) void'(mq.pop_front());
    else if (mq.size() == 1) pend_m = 1;
  endtask

  task automatic model_fall();
    if (pend_m) begin
      last_m = mq.pop_front();
      pend_m = 0;
    end
  endtask

  task automatic set_rd(logic v);
    if (fifo_mode && v && !rd_line) model_rise();
    if (fifo_mode && !v && rd_line) model_fall();
    rd_line = v;
    if (!fifo_mode && !v) model_clear();
    settle();
  endtask

  task automatic set_mode(logic m);
    fifo_mode = m;
    if (!m && !rd_line) model_clear();
    settle();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R12
    chk(dout === 18'h0, "R12 reset dout", 32'(dout), 0);
    chk({st_upper, st_lower} === 2'b01, "R12 reset status", 32'({st_upper, st_lower}), 1);

    // R3 R4: first write with read line high falls through
    do_write(18'h2_A5A5);
    check_all("R4 fall-through");
    do_write(18'h1_0001);
    check_all("R3 second write holds oldest");

    // fill to 16, then R8 discard
    for (int i = 2; i < 16; i++) begin
      do_write(18'(i * 18'h0111));
      if (i == 7 || i == 8) check_all("R9 half boundary");
    end
    check_all("R9 full");
    do_write(18'h3_FFFF);
    check_all("R8 17th write discarded");

    // R11: collision while full, write first then read
    rd_line = 1'b0;
    settle();
    @(negedge clk);
    rd_line = 1'b1;
    @(negedge clk);
    @(negedge clk);
    din = 18'h3_BEEF;
    eoc = 1'b0;
    model_rise();
    settle();
    eoc = 1'b1;
    @(negedge clk);
    check_all("R11 write-then-read collision");
    chk(mq.size() == 15, "R11 model depth", 32'(mq.size()), 15);

    // R5: drain down to last word
    while (!pend_m) begin
      set_rd(1'b0);
      set_rd(1'b1);
      check_all("R5 read advance");
    end
    check_all("R6 last word still shown");
    set_rd(1'b0);
    check_all("R6 falling edge empties");
    // R7
    set_rd(1'b1);
    check_all("R7 empty read rise");
    set_rd(1'b0);
    set_rd(1'b1);
    check_all("R7 empty read again");

    // R1 R2: direct mode with read line high
    do_write(18'h0_1111);
    do_write(18'h0_2222);
    do_write(18'h0_3333);
    set_mode(1'b0);
    din = 18'h2_CAFE;
    #1;
    chk(dout === 18'h2_CAFE, "R1 pass-through", 32'(dout), 32'h2CAFE);
    @(negedge clk);
    do_write(18'h1_D00D);
    set_rd(1'b1);
    check_all("R2 direct ignores write");
    set_mode(1'b1);
    check_all("R2 contents kept");

    // R10: soft clear
    set_mode(1'b0);
    set_rd(1'b0);
    check_all("R10 soft clear");
    set_rd(1'b1);
    set_mode(1'b1);
    check_all("R10 after return");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom_range(0, 9));
      if (r < 5) do_write(18'($urandom()));
      else if (r < 9) set_rd(~rd_line);
      else set_mode(~fifo_mode);
      check_all("R3 R5 R9 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule